// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index Qualification

This block turns the raw phase inputs of an incremental encoder, together with its active-low marker input, into the strobes a position counter needs. It emits a one-cycle count strobe, a direction level and a one-cycle index strobe. It does not hold a count value. All three inputs pass through a synchroniser. In quadrature operation, the phase inputs and the marker input then pass through a glitch filter. The filter accepts a new level only after the same value has been sampled on three consecutive filter ticks. A tick is either every system clock or every second system clock.

A two-bit resolution select chooses between four modes. The first is plain count/direction, where a rising edge of A counts and B gives the direction. The other three are x1, x2 and x4 quadrature decoding. The marker can be qualified synchronously: it is filtered and accepted only while A and B are at equal levels. It can also be taken asynchronously, where any synchronised falling edge is accepted. Count/direction mode always takes the marker asynchronously. If A and B both move in the same filter step, the decoder produces no count and raises a one-cycle phase error instead.

Top module: `quad_index_decoder`

## Requirements
- R1: With modeSel = 2'b11 (x4), every legal step of the filtered {A,B} state gives one count strobe. The state cycles 00, 10, 11, 01. A step forward in that cycle sets countUp = 1, and a step backward sets countUp = 0.
- R2: With modeSel = 2'b10 (x2), only legal steps that change A give a count, with the direction defined as in R1.
- R3: With modeSel = 2'b01 (x1), only the step 00 to 10 counts, and it counts up. Only the step 10 to 00 counts down. No other step counts.
- R4: In a quadrature mode, a filter step in which A and B both change gives no count strobe and a phaseErr pulse of exactly one cycle.
- R5: With divBy2 = 0, a level on A that lasts 2 clock cycles is ignored. A level that lasts 3 cycles is accepted.
- R6: With divBy2 = 0, a quadrature count strobe is high in the fifth clock cycle after the input changes. This delay is made up of two synchroniser stages followed by three filter samples.
- R7: With divBy2 = 1, the filter samples on every second clock. A 3-cycle level is ignored, and a count strobe appears 7 or 8 cycles after the input changes.
- R8: With modeSel = 2'b00, A and B are not filtered. Each synchronised rising edge of A gives a count 2 cycles after the edge, even if A is high for only one cycle. B high means up and B low means down. A falling edge of A gives no count.
- R9: With syncIndex = 1 in a quadrature mode, the filtered index going low while A equals B gives one indexPulse, 5 cycles after the change. Holding the index low gives no second pulse.
- R10: With syncIndex = 1 in a quadrature mode, an index held low while A differs from B gives no indexPulse.
- R11: With syncIndex = 0, or with modeSel = 2'b00, any falling edge of indexN gives one indexPulse 2 cycles later, whatever the phase of A and B.
- R12: After reset, countPulse, indexPulse and phaseErr are 0 and countUp is 1.
- R13: countPulse and indexPulse never stay high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | 00 count/direction, 01 x1, 10 x2, 11 x4 |
| divBy2 | input | 1 | 1: filter samples on every second clock |
| syncIndex | input | 1 | 1: phase-qualified filtered index (quadrature modes only) |
| inA | input | 1 | Raw phase A, or the count input |
| inB | input | 1 | Raw phase B, or the direction input |
| indexN | input | 1 | Raw active-low index marker |
| countPulse | output | 1 | One-cycle count strobe |
| countUp | output | 1 | Direction of the current or most recent count |
| indexPulse | output | 1 | One-cycle qualified index strobe |
| phaseErr | output | 1 | One-cycle strobe on a double phase change |

## Verification
The hardest case to reach is the illegal double step. It only occurs when the A and B filters accept their new levels on the same tick. The bench therefore changes both raw inputs on the same clock edge, from every one of the four states, so the two filters fill in lockstep. The divide-by-two window is the other awkward case, because the tick phase is unknown. The bench uses a 3-cycle level, which never covers three ticks, and it accepts either of the two possible strobe positions.

// File: rtl/qdec_pkg.sv
`timescale 1ns/1ps
package qdec_pkg;

  typedef enum logic [1:0] {
    RES_CNTDIR = 2'b00,
    RES_X1     = 2'b01,
    RES_X2     = 2'b10,
    RES_X4     = 2'b11
  } resMode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic     sampleTick;
    logic     quadOn;
    logic     idxQualify;
    resMode_e res;
  } dpStrobe_t;

  localparam int NUM_CH = 3;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_IDX = 2;

  // position of an {A,B} state along the forward cycle 00,10,11,01
  function automatic logic [1:0] phasePos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qdec_sync.sv
`timescale 1ns/1ps
module qdec_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_LVL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qdec_glitch_filter.sv
`timescale 1ns/1ps
module qdec_glitch_filter #(
  parameter int   DEPTH   = 3,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic din,
  output logic level
);
  localparam int HIST = DEPTH - 1;

  logic [HIST-1:0]  hist;
  logic [DEPTH-1:0] window;
  logic             lvl;

  assign window = {hist, din};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= {HIST{RST_LVL}};
      lvl  <= RST_LVL;
    end else if (tick) begin
      hist <= window[HIST-1:0];
      if (&window)       lvl <= 1'b1;
      else if (~|window) lvl <= 1'b0;
    end
  end

  assign level = lvl;
endmodule

// File: rtl/qdec_ctrl.sv
`timescale 1ns/1ps
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       divBy2,
  input  logic       syncIndex,
  output dpStrobe_t  strb
);
  logic tickPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickPh <= 1'b0;
    else       tickPh <= !tickPh;
  end

  always_comb begin
    strb.res        = resMode_e'(modeSel);
    strb.quadOn     = (resMode_e'(modeSel) != RES_CNTDIR);
    strb.sampleTick = divBy2 ? tickPh : 1'b1;
    strb.idxQualify = syncIndex && strb.quadOn;
  end
endmodule

// File: rtl/qdec_datapath.sv
`timescale 1ns/1ps
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strb,
  input  logic      rawA,
  input  logic      rawB,
  input  logic      rawIdxN,
  output logic      countPulse,
  output logic      countUp,
  output logic      indexPulse,
  output logic      phaseErr
);
  localparam logic [NUM_CH-1:0] RST_LVLS = NUM_CH'(1) << CH_IDX;

  logic [NUM_CH-1:0] rawVec, syncVec, filtVec;
  assign rawVec = {rawIdxN, rawB, rawA};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    qdec_sync #(.STAGES(SYNC_STAGES), .RST_LVL(RST_LVLS[ch])) u_sync (
      .clk(clk), .rstN(rstN), .din(rawVec[ch]), .dout(syncVec[ch])
    );
    qdec_glitch_filter #(.DEPTH(FILT_DEPTH), .RST_LVL(RST_LVLS[ch])) u_filt (
      .clk(clk), .rstN(rstN), .tick(strb.sampleTick),
      .din(syncVec[ch]), .level(filtVec[ch])
    );
  end

  logic prevA, prevB, syncAPrev, syncIdxPrev, idxArmed, lastDir;
  logic [1:0] posOld, posNew, step;
  logic aMoved, legalStep, qUp, qCount, cdCount, dirNow;
  logic qualNow, qualPulse, asyncIdx;

  always_comb begin
    posOld    = phasePos(prevA, prevB);
    posNew    = phasePos(filtVec[CH_A], filtVec[CH_B]);
    step      = posNew - posOld;
    aMoved    = filtVec[CH_A] ^ prevA;
    legalStep = (step == 2'd1) || (step == 2'd3);
    qUp       = (step == 2'd1);
    case (strb.res)
      RES_X4:  qCount = legalStep;
      RES_X2:  qCount = legalStep && aMoved;
      RES_X1:  qCount = legalStep && aMoved && !filtVec[CH_B];
      default: qCount = 1'b0;
    endcase
    cdCount    = syncVec[CH_A] && !syncAPrev;
    countPulse = strb.quadOn ? qCount : cdCount;
    dirNow     = strb.quadOn ? qUp : syncVec[CH_B];
    countUp    = countPulse ? dirNow : lastDir;
    phaseErr   = strb.quadOn && (step == 2'd2);

    qualNow    = !filtVec[CH_IDX] && (filtVec[CH_A] ~^ filtVec[CH_B]);
    qualPulse  = qualNow && idxArmed;
    asyncIdx   = !syncVec[CH_IDX] && syncIdxPrev;
    indexPulse = strb.idxQualify ? qualPulse : asyncIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA       <= 1'b0;
      prevB       <= 1'b0;
      syncAPrev   <= 1'b0;
      syncIdxPrev <= 1'b1;
      idxArmed    <= 1'b0;
      lastDir     <= 1'b1;
    end else begin
      prevA       <= filtVec[CH_A];
      prevB       <= filtVec[CH_B];
      syncAPrev   <= syncVec[CH_A];
      syncIdxPrev <= syncVec[CH_IDX];
      if (filtVec[CH_IDX]) idxArmed <= 1'b1;
      else if (qualPulse)  idxArmed <= 1'b0;
      if (countPulse) lastDir <= dirNow;
    end
  end
endmodule

// File: rtl/quad_index_decoder.sv
`timescale 1ns/1ps
module quad_index_decoder
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       divBy2,
  input  logic       syncIndex,
  input  logic       inA,
  input  logic       inB,
  input  logic       indexN,
  output logic       countPulse,
  output logic       countUp,
  output logic       indexPulse,
  output logic       phaseErr
);
  dpStrobe_t strb;

  qdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .divBy2(divBy2),
    .syncIndex(syncIndex), .strb(strb)
  );

  qdec_datapath #(.SYNC_STAGES(SYNC_STAGES), .FILT_DEPTH(FILT_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rawA(inA), .rawB(inB), .rawIdxN(indexN),
    .countPulse(countPulse), .countUp(countUp),
    .indexPulse(indexPulse), .phaseErr(phaseErr)
  );
endmodule

// File: rtl/qdec_checker.sv
`timescale 1ns/1ps
module qdec_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       inA,
  input logic       countPulse,
  input logic       indexPulse,
  input logic       phaseErr
);
  // R13
  single_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |=> !countPulse);

  // R13
  single_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    indexPulse |=> !indexPulse);

  // R4
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(countPulse && phaseErr));

  // R4
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseErr |=> !phaseErr);

  // R8
  cd_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countPulse && modeSel == 2'b00) |-> ($past(inA, 2) && !$past(inA, 3)));
endmodule

bind quad_index_decoder qdec_checker i_qdec_checker (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .inA(inA),
  .countPulse(countPulse), .indexPulse(indexPulse), .phaseErr(phaseErr)
);

// File: tb/test_quad_index_decoder.sv
`timescale 1ns/1ps
module test_quad_index_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic divBy2 = 1'b0, syncIndex = 1'b0;
  logic inA = 1'b0, inB = 1'b0, indexN = 1'b1;
  logic countPulse, countUp, indexPulse, phaseErr;

  int nChecks = 0, nFails = 0;
  int nCnt, nUp, nErr, nIdx, firstCnt, firstIdx;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_index_decoder i_quad_index_decoder (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .divBy2(divBy2),
    .syncIndex(syncIndex), .inA(inA), .inB(inB), .indexN(indexN),
    .countPulse(countPulse), .countUp(countUp),
    .indexPulse(indexPulse), .phaseErr(phaseErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // set inputs at a falling edge, then tally outputs over n falling edges
  task automatic drive(input logic a, input logic b, input logic idx, input int n);
    @(negedge clk);
    inA = a; inB = b; indexN = idx;
    nCnt = 0; nUp = 0; nErr = 0; nIdx = 0; firstCnt = 0; firstIdx = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (countPulse) begin
        nCnt++;
        if (countUp) nUp++;
        if (firstCnt == 0) firstCnt = i;
      end
      if (phaseErr) nErr++;
      if (indexPulse) begin
        nIdx++;
        if (firstIdx == 0) firstIdx = i;
      end
    end
  endtask

  function automatic int gpos(input logic [1:0] ab);
    return ab[1] ? (ab[0] ? 2 : 1) : (ab[0] ? 3 : 0);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int tot;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12
    chk(countPulse == 0, "R12 countPulse", countPulse, 0);
    chk(indexPulse == 0, "R12 indexPulse", indexPulse, 0);
    chk(phaseErr == 0, "R12 phaseErr", phaseErr, 0);
    chk(countUp == 1, "R12 countUp", countUp, 1);

    // sweep of all state pairs in each quadrature mode (R1 R2 R3 R4)
    for (int m = 1; m <= 3; m++) begin
      modeSel = 2'(m);
      for (int f = 0; f < 4; f++) begin
        for (int t = 0; t < 4; t++) begin
          if (f != t) begin
            logic [1:0] fs, ts;
            int d, expCnt, expUp, expErr;
            bit legal, aCh;
            string tag;
            fs = 2'(f); ts = 2'(t);
            drive(fs[1], fs[0], 1'b1, 12);
            drive(ts[1], ts[0], 1'b1, 12);
            d = (gpos(ts) - gpos(fs) + 4) % 4;
            legal = (d == 1) || (d == 3);
            aCh = fs[1] != ts[1];
            if (m == 3)      begin expCnt = int'(legal);                    tag = "R1"; end
            else if (m == 2) begin expCnt = int'(legal && aCh);             tag = "R2"; end
            else             begin expCnt = int'(legal && aCh && !ts[0]);   tag = "R3"; end
            expUp = (expCnt == 1 && d == 1) ? 1 : 0;
            expErr = (d == 2) ? 1 : 0;
            chk(nCnt == expCnt, $sformatf("%s count %0d->%0d", tag, f, t), nCnt, expCnt);
            chk(nUp == expUp, $sformatf("%s dir %0d->%0d", tag, f, t), nUp, expUp);
            chk(nErr == expErr, $sformatf("R4 err m%0d %0d->%0d", m, f, t), nErr, expErr);
          end
        end
      end
    end

    // R6 latency and R13 single strobe, x4, divide by 1
    modeSel = 2'b11;
    drive(0, 0, 1, 12);
    drive(1, 0, 1, 12);
    chk(firstCnt == 5, "R6 latency", firstCnt, 5);
    chk(nCnt == 1, "R13 single strobe", nCnt, 1);

    // R5 filter width
    drive(0, 0, 1, 12);
    drive(1, 0, 1, 1); tot = nCnt;
    drive(0, 0, 1, 14); tot += nCnt;
    chk(tot == 0, "R5 two-cycle level", tot, 0);
    drive(1, 0, 1, 2); tot = nCnt;
    drive(0, 0, 1, 14); tot += nCnt;
    chk(tot == 2, "R5 three-cycle level", tot, 2);

    // R7 divide by two
    divBy2 = 1'b1;
    drive(0, 0, 1, 12);
    drive(1, 0, 1, 14);
    chk(nCnt == 1, "R7 count", nCnt, 1);
    chk(firstCnt >= 7 && firstCnt <= 8, "R7 latency", firstCnt, 7);
    drive(0, 0, 1, 14);
    drive(1, 0, 1, 2); tot = nCnt;
    drive(0, 0, 1, 16); tot += nCnt;
    chk(tot == 0, "R7 three-cycle level", tot, 0);
    divBy2 = 1'b0;

    // R9 R10 synchronous index
    syncIndex = 1'b1;
    drive(1, 1, 1, 12);
    drive(1, 1, 0, 14);
    chk(nIdx == 1, "R9 index at 11", nIdx, 1);
    chk(firstIdx == 5, "R9 index latency", firstIdx, 5);
    drive(1, 1, 1, 10);
    drive(0, 0, 1, 12);
    drive(0, 0, 0, 14);
    chk(nIdx == 1, "R9 index at 00", nIdx, 1);
    drive(0, 0, 1, 10);
    drive(1, 0, 1, 12);
    drive(1, 0, 0, 14);
    chk(nIdx == 0, "R10 index at 10", nIdx, 0);
    drive(1, 0, 1, 10);

    // R11 asynchronous index
    syncIndex = 1'b0;
    drive(1, 0, 0, 14);
    chk(nIdx == 1, "R11 async count", nIdx, 1);
    chk(firstIdx == 2, "R11 async latency", firstIdx, 2);
    drive(1, 0, 1, 10);
    syncIndex = 1'b1;
    modeSel = 2'b00;
    drive(1, 0, 1, 10);
    drive(1, 0, 0, 10);
    chk(nIdx == 1, "R11 cd forced async", nIdx, 1);
    chk(firstIdx == 2, "R11 cd latency", firstIdx, 2);
    drive(1, 0, 1, 10);

    // R8 count/direction
    drive(0, 1, 1, 8);
    drive(1, 1, 1, 8);
    chk(nCnt == 1, "R8 rise count", nCnt, 1);
    chk(nUp == 1, "R8 up", nUp, 1);
    chk(firstCnt == 2, "R8 latency", firstCnt, 2);
    drive(0, 1, 1, 8);
    chk(nCnt == 0, "R8 fall ignored", nCnt, 0);
    drive(0, 0, 1, 8);
    drive(1, 0, 1, 8);
    chk(nCnt == 1 && nUp == 0, "R8 down", nUp, 0);
    drive(0, 0, 1, 8);
    drive(1, 0, 1, 0); tot = nCnt;
    drive(0, 0, 1, 8); tot += nCnt;
    chk(tot == 1, "R8 one-cycle pulse", tot, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule